// File: doc/BRIEF.md
# Nibble-Wide Register Interface with Sticky Status

This block sits between a host processor and a tone transceiver and gives the host a 4-bit register port. The host drives a strobe that need not be periodic, an active-low select, one address bit, a read/write line and a 4-bit data nibble. All of these inputs are asynchronous. The block brings them into the system clock domain through two-flop synchronizers and finds strobe edges from the synchronized copy. A write takes the nibble when the strobe falls. A read loads its nibble when the strobe rises and drives it until the strobe falls. The data bus comes out as a separate input, output and output-enable, so the pad ring can build the tri-state pin.

The address bit and the read/write line select one of four registers: the transmit digit (write), the receive digit (read), control (write) and status (read). Control writes normally go to register A. Setting the bank-select bit in register A sends exactly one following control write to register B. The status register reports a live receive-invalid bit and two sticky event flags, and also shows their OR. A status read clears only the flags that the read itself reported. If a new event lands in the clearing cycle, the event wins. A power-down input clears every register, every flag, any pending bank select and any open access.

An access sequencer with three states runs each transfer. ACC_IDLE waits for a rising strobe while select is low, then moves to ACC_READ or ACC_WRITE according to the read/write line. ACC_READ drives the bus and returns to ACC_IDLE when the strobe falls (completion) or select goes high (abort). ACC_WRITE commits the write and returns to ACC_IDLE when the strobe falls, or returns without writing when select goes high. Power-down forces ACC_IDLE from any state.

Top module: `nbi_regif`

## Requirements
- R1: After reset, every control output and the transmit digit are 0, both flags are 0, and `bus_oe` is 0.
- R2: `bus_oe` is 1 only during a read access, from just after the rising strobe (select low, `rd_nwr`=1) until just after the falling strobe. It stays 0 through write accesses.
- R3: A write with `reg_addr`=0 and `rd_nwr`=0 stores the nibble in `tx_digit` on the falling strobe.
- R4: A read with `reg_addr`=0 and `rd_nwr`=1 returns `rx_digit` as it was at the rising strobe.
- R5: A control write (`reg_addr`=1, `rd_nwr`=0) to register A sets bit 2 into `det_en` and bit 0 into `tone_tx_en`, and bit 3 arms the bank select. Bit 1 has no effect.
- R6: While the bank select is armed, the next control write goes to register B instead: bits 3:2 set `cpt_freq`, bit 1 sets `cpt_tx_en`, bit 0 has no effect, and register A is left unchanged. The write after that goes to register A again.
- R7: A status read (`reg_addr`=1, `rd_nwr`=1) returns bit 3 = `rx_invalid`, bit 2 = digit flag, bit 1 = call-progress flag, and bit 0 = the OR of the two flags.
- R8: A pulse on `rx_evt` or `cp_evt` sets its flag, and the flag stays set until a status read that reported it as 1 completes. A flag set after the read began is not cleared by that read.
- R9: When an event pulse and the end of a status read fall in the same cycle, the flag stays set.
- R10: While `pdn` is high, all registers, both flags and the armed bank select are cleared, and `bus_oe` drops.
- R11: Strobes while `sel_n` is high neither write anything nor drive the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pdn | input | 1 | Power-down; clears all state while high |
| strobe | input | 1 | Host transfer strobe, asynchronous |
| sel_n | input | 1 | Active-low select, asynchronous |
| reg_addr | input | 1 | Register address bit |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| bus_in | input | 4 | Data nibble from host |
| bus_out | output | 4 | Read data nibble |
| bus_oe | output | 1 | Enable for the bus drivers |
| rx_digit | input | 4 | Receive digit from the tone logic |
| rx_invalid | input | 1 | 1 when the receive digit is not valid |
| rx_evt | input | 1 | One-cycle pulse: digit received |
| cp_evt | input | 1 | One-cycle pulse: call progress detected |
| tx_digit | output | 4 | Transmit digit register |
| tone_tx_en | output | 1 | Digit tone transmit enable (register A) |
| det_en | output | 1 | Detector enable (register A) |
| cpt_freq | output | 2 | Call-progress frequency select (register B) |
| cpt_tx_en | output | 1 | Call-progress transmit enable (register B) |

## Verification
Two things can meet in one cycle: a status read completing, which clears the flags it reported, and a tone event setting a flag. The bench makes them meet by raising `cp_evt` in exactly the cycle in which the synchronized falling strobe takes effect, two clock edges after the raw strobe falls. It then requires a second status read to still show the call-progress flag and the OR bit. A second case pulses `rx_evt` between the rising and falling strobes of a status read, so the clear and a new set are close but in different cycles. There the digit flag must survive because the read never reported it.

// File: rtl/nbi_pkg.sv
package nbi_pkg;
    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_state_t;

    // {address bit, read line}
    typedef enum logic [1:0] {
        SEL_TX   = 2'b00,
        SEL_RX   = 2'b01,
        SEL_CTL  = 2'b10,
        SEL_STAT = 2'b11
    } reg_sel_t;
endpackage

// File: rtl/nbi_sync.sv
module nbi_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) chain[k] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/nbi_access_fsm.sv
module nbi_access_fsm import nbi_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic pdn,
    input  logic strobe_s,
    input  logic sel_n_s,
    input  logic rd_s,
    output logic snap,
    output logic wr_fire,
    output logic rd_done,
    output logic bus_oe
);
    acc_state_t state, nxt;
    logic strobe_d;
    logic rise, fall;

    assign rise = strobe_s & ~strobe_d;
    assign fall = ~strobe_s & strobe_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ACC_IDLE;
            strobe_d <= 1'b0;
        end else begin
            strobe_d <= strobe_s;
            state    <= pdn ? ACC_IDLE : nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ACC_IDLE:  if (rise && !sel_n_s) nxt = rd_s ? ACC_READ : ACC_WRITE;
            ACC_READ:  if (sel_n_s || fall) nxt = ACC_IDLE;
            ACC_WRITE: if (sel_n_s || fall) nxt = ACC_IDLE;
            default:   nxt = ACC_IDLE;
        endcase
    end

    always_comb begin
        snap    = 1'b0;
        wr_fire = 1'b0;
        rd_done = 1'b0;
        bus_oe  = 1'b0;
        unique case (state)
            ACC_IDLE:  snap = rise && !sel_n_s && rd_s && !pdn;
            ACC_READ: begin
                bus_oe  = 1'b1;
                rd_done = fall && !sel_n_s && !pdn;
            end
            ACC_WRITE: wr_fire = fall && !sel_n_s && !pdn;
            default: ;
        endcase
    end

    assert_oe_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> $past(!sel_n_s && rd_s && strobe_s));
    assert_oe_off_in_pdn_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pdn |=> !bus_oe);
    assert_no_write_unselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |-> !sel_n_s);
endmodule

// File: rtl/nbi_ctl.sv
module nbi_ctl #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pdn,
    input  logic         wr_tx,
    input  logic         wr_ctl,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] tx_digit,
    output logic         tone_tx_en,
    output logic         det_en,
    output logic [1:0]   cpt_freq,
    output logic         cpt_tx_en
);
    logic sel_b_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_digit <= '0; tone_tx_en <= 1'b0; det_en <= 1'b0;
            cpt_freq <= '0; cpt_tx_en <= 1'b0; sel_b_pend <= 1'b0;
        end else if (pdn) begin
            tx_digit <= '0; tone_tx_en <= 1'b0; det_en <= 1'b0;
            cpt_freq <= '0; cpt_tx_en <= 1'b0; sel_b_pend <= 1'b0;
        end else begin
            if (wr_tx) tx_digit <= wdata;
            if (wr_ctl) begin
                if (sel_b_pend) begin
                    cpt_freq   <= wdata[3:2];
                    cpt_tx_en  <= wdata[1];
                    sel_b_pend <= 1'b0;
                end else begin
                    det_en     <= wdata[2];
                    tone_tx_en <= wdata[0];
                    sel_b_pend <= wdata[3];
                end
            end
        end
    end

    assert_bank_one_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && sel_b_pend && !pdn) |=> (!sel_b_pend && $stable(det_en) && $stable(tone_tx_en)));
    assert_pdn_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pdn |=> (!sel_b_pend && !det_en && !tone_tx_en && !cpt_tx_en && cpt_freq == 2'b00 && tx_digit == '0));
endmodule

// File: rtl/nbi_status.sv
module nbi_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdn,
    input  logic       rx_evt,
    input  logic       cp_evt,
    input  logic       clr_en,
    input  logic [1:0] clr_mask,   // {digit, call progress} as reported
    output logic       sp_flag,
    output logic       cp_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_flag <= 1'b0;
            cp_flag <= 1'b0;
        end else if (pdn) begin
            sp_flag <= 1'b0;
            cp_flag <= 1'b0;
        end else begin
            sp_flag <= rx_evt | (sp_flag & ~(clr_en & clr_mask[1]));
            cp_flag <= cp_evt | (cp_flag & ~(clr_en & clr_mask[0]));
        end
    end

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdn && cp_evt && clr_en) |=> cp_flag);
    assert_reported_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdn && clr_en && clr_mask[1] && !rx_evt) |=> !sp_flag);
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdn && cp_flag && !clr_en) |=> cp_flag);
endmodule

// File: rtl/nbi_regif.sv
module nbi_regif import nbi_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pdn,
    input  logic             strobe,
    input  logic             sel_n,
    input  logic             reg_addr,
    input  logic             rd_nwr,
    input  logic [NIB_W-1:0] bus_in,
    output logic [NIB_W-1:0] bus_out,
    output logic             bus_oe,
    input  logic [NIB_W-1:0] rx_digit,
    input  logic             rx_invalid,
    input  logic             rx_evt,
    input  logic             cp_evt,
    output logic [NIB_W-1:0] tx_digit,
    output logic             tone_tx_en,
    output logic             det_en,
    output logic [1:0]       cpt_freq,
    output logic             cpt_tx_en
);
    localparam int CTL_W = 4;
    localparam logic [CTL_W-1:0] CTL_RST = 4'b0100;

    logic [CTL_W-1:0] ctl_s;
    logic [NIB_W-1:0] data_s;
    logic snap, wr_fire, rd_done;
    logic sp_flag, cp_flag;
    logic [NIB_W-1:0] rd_nib_q, stat_nib;
    logic rd_stat_q;
    logic [1:0] clr_mask_q;
    reg_sel_t cur_sel;

    nbi_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n), .d({strobe, sel_n, reg_addr, rd_nwr}), .q(ctl_s));
    nbi_sync #(.W(NIB_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .d(bus_in), .q(data_s));

    assign cur_sel = reg_sel_t'(ctl_s[1:0]);

    nbi_access_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pdn(pdn),
        .strobe_s(ctl_s[3]), .sel_n_s(ctl_s[2]), .rd_s(ctl_s[0]),
        .snap(snap), .wr_fire(wr_fire), .rd_done(rd_done), .bus_oe(bus_oe));

    nbi_ctl #(.W(NIB_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .pdn(pdn),
        .wr_tx(wr_fire && cur_sel == SEL_TX),
        .wr_ctl(wr_fire && cur_sel == SEL_CTL),
        .wdata(data_s),
        .tx_digit(tx_digit), .tone_tx_en(tone_tx_en), .det_en(det_en),
        .cpt_freq(cpt_freq), .cpt_tx_en(cpt_tx_en));

    nbi_status u_status (
        .clk(clk), .rst_n(rst_n), .pdn(pdn),
        .rx_evt(rx_evt), .cp_evt(cp_evt),
        .clr_en(rd_done && rd_stat_q), .clr_mask(clr_mask_q),
        .sp_flag(sp_flag), .cp_flag(cp_flag));

    assign stat_nib = {rx_invalid, sp_flag, cp_flag, sp_flag | cp_flag};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_nib_q <= '0; rd_stat_q <= 1'b0; clr_mask_q <= '0;
        end else if (pdn) begin
            rd_nib_q <= '0; rd_stat_q <= 1'b0; clr_mask_q <= '0;
        end else if (snap) begin
            rd_nib_q   <= (cur_sel == SEL_STAT) ? stat_nib : rx_digit;
            rd_stat_q  <= (cur_sel == SEL_STAT);
            clr_mask_q <= {sp_flag, cp_flag};
        end
    end

    assign bus_out = bus_oe ? rd_nib_q : '0;

    assert_no_drive_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |-> !bus_oe);
endmodule

// File: tb/test_nbi_regif.sv
module test_nbi_regif;
    logic clk = 1'b0;
    logic rst_n = 1'b0, pdn = 1'b0;
    logic strobe = 1'b0, sel_n = 1'b1, reg_addr = 1'b0, rd_nwr = 1'b0;
    logic [3:0] bus_in = '0, rx_digit = '0;
    logic rx_invalid = 1'b1, rx_evt = 1'b0, cp_evt = 1'b0;
    logic [3:0] bus_out, tx_digit;
    logic bus_oe, tone_tx_en, det_en, cpt_tx_en;
    logic [1:0] cpt_freq;

    int total = 0, bad = 0;
    bit done = 1'b0;

    // model
    logic [3:0] m_tx = '0;
    logic m_tone = 1'b0, m_det = 1'b0, m_pend = 1'b0, m_cpt = 1'b0;
    logic [1:0] m_freq = '0;
    logic m_sp = 1'b0, m_cp = 1'b0;

    always #5 clk = ~clk;

    nbi_regif i_nbi_regif (
        .clk(clk), .rst_n(rst_n), .pdn(pdn), .strobe(strobe), .sel_n(sel_n),
        .reg_addr(reg_addr), .rd_nwr(rd_nwr), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .rx_digit(rx_digit), .rx_invalid(rx_invalid),
        .rx_evt(rx_evt), .cp_evt(cp_evt), .tx_digit(tx_digit),
        .tone_tx_en(tone_tx_en), .det_en(det_en), .cpt_freq(cpt_freq),
        .cpt_tx_en(cpt_tx_en));

    function automatic logic [3:0] stat_exp(input logic inv, input logic sp, input logic cp);
        return {inv, sp, cp, sp | cp};
    endfunction

    function automatic logic [8:0] outs_exp();
        return {m_tx, m_tone, m_det, m_freq, m_cpt};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_outs(input string req);
        check(req, {23'd0, tx_digit, tone_tx_en, det_en, cpt_freq, cpt_tx_en}, {23'd0, outs_exp()});
    endtask

    task automatic model_ctl(input logic [3:0] d);
        if (m_pend) begin
            m_freq = d[3:2]; m_cpt = d[1]; m_pend = 1'b0;
        end else begin
            m_det = d[2]; m_tone = d[0]; m_pend = d[3];
        end
    endtask

    task automatic do_write(input logic a, input logic [3:0] d, input logic selected);
        @(negedge clk);
        sel_n = ~selected; reg_addr = a; rd_nwr = 1'b0; bus_in = d;
        idle(3); strobe = 1'b1; idle(5);
        check("R2 no drive during write", {31'd0, bus_oe}, 32'd0);
        strobe = 1'b0; idle(5);
        sel_n = 1'b1; idle(2);
    endtask

    task automatic do_read(input logic a, input int mode, output logic [3:0] val);
        @(negedge clk);
        sel_n = 1'b0; reg_addr = a; rd_nwr = 1'b1;
        idle(3); strobe = 1'b1; idle(5);
        check("R2 drive during read", {31'd0, bus_oe}, 32'd1);
        val = bus_out;
        if (mode == 2) begin
            rx_evt = 1'b1; @(negedge clk); rx_evt = 1'b0; idle(2);
        end
        strobe = 1'b0;
        if (mode == 1) begin
            @(posedge clk); @(posedge clk); @(negedge clk);
            cp_evt = 1'b1; @(negedge clk); cp_evt = 1'b0;
        end
        idle(5);
        check("R2 release after read", {31'd0, bus_oe}, 32'd0);
        sel_n = 1'b1; idle(2);
    endtask

    task automatic pulse(input logic sp, input logic cp);
        @(negedge clk); rx_evt = sp; cp_evt = cp;
        @(negedge clk); rx_evt = 1'b0; cp_evt = 1'b0;
        if (sp) m_sp = 1'b1;
        if (cp) m_cp = 1'b1;
    endtask

    task automatic status_read(input string req);
        logic [3:0] v;
        do_read(1'b1, 0, v);
        check(req, {28'd0, v}, {28'd0, stat_exp(rx_invalid, m_sp, m_cp)});
        m_sp = 1'b0; m_cp = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [3:0] v;
        void'($urandom(32'd2024));
        idle(3); rst_n = 1'b1; idle(3);

        // R1 reset state
        check_outs("R1 reset outputs");
        check("R1 reset oe", {31'd0, bus_oe}, 32'd0);
        status_read("R1 reset flags");

        // R3 transmit digit
        do_write(1'b0, 4'h9, 1'b1); m_tx = 4'h9;
        check_outs("R3 tx write");

        // R5 register A, bit1 ignored
        do_write(1'b1, 4'b0101, 1'b1); model_ctl(4'b0101);
        check_outs("R5 ctl A write");
        do_write(1'b1, 4'b0111, 1'b1); model_ctl(4'b0111);
        check_outs("R5 bit1 ignored");

        // R6 one-shot bank B
        do_write(1'b1, 4'b1000, 1'b1); model_ctl(4'b1000);
        check_outs("R6 arm bank B");
        do_write(1'b1, 4'b1110, 1'b1); model_ctl(4'b1110);
        check_outs("R6 bank B write");
        do_write(1'b1, 4'b0001, 1'b1); model_ctl(4'b0001);
        check_outs("R6 back to A");
        do_write(1'b1, 4'b1001, 1'b1); model_ctl(4'b1001);
        do_write(1'b1, 4'b0011, 1'b1); model_ctl(4'b0011);
        check_outs("R6 bank B bit0 ignored");

        // R11 unselected strobe ignored
        do_write(1'b0, 4'hF, 1'b0);
        check_outs("R11 unselected write ignored");

        // R4 receive digit
        rx_digit = 4'hC;
        do_read(1'b0, 0, v);
        check("R4 rx read", {28'd0, v}, 32'hC);

        // R7/R8 status
        rx_invalid = 1'b1;
        status_read("R7 status idle");
        rx_invalid = 1'b0;
        pulse(1'b1, 1'b0);
        status_read("R7 digit flag");
        status_read("R8 digit flag cleared");
        pulse(1'b0, 1'b1);
        status_read("R7 cp flag");
        status_read("R8 cp flag cleared");

        // R9 set in the clearing cycle
        pulse(1'b0, 1'b1);
        do_read(1'b1, 1, v);
        check("R9 collision read", {28'd0, v}, {28'd0, stat_exp(1'b0, 1'b0, 1'b1)});
        status_read("R9 flag survives clear");

        // R8 flag set mid-read is kept
        do_read(1'b1, 2, v);
        check("R8 mid-read snapshot", {28'd0, v}, 32'h0);
        m_sp = 1'b1;
        status_read("R8 late flag kept");

        // R10 power-down
        do_write(1'b0, 4'h6, 1'b1); m_tx = 4'h6;
        do_write(1'b1, 4'b1101, 1'b1); model_ctl(4'b1101);
        pulse(1'b1, 1'b1);
        @(negedge clk); pdn = 1'b1; idle(2); pdn = 1'b0; idle(1);
        m_tx = '0; m_tone = 1'b0; m_det = 1'b0; m_pend = 1'b0; m_freq = '0; m_cpt = 1'b0;
        m_sp = 1'b0; m_cp = 1'b0;
        check_outs("R10 pdn clears regs");
        do_write(1'b1, 4'b0001, 1'b1); model_ctl(4'b0001);
        check_outs("R10 pending select cleared");
        status_read("R10 flags cleared");

        // random mix
        for (int it = 0; it < 80; it++) begin
            int op;
            logic [3:0] d;
            op = int'($urandom % 5);
            d = 4'($urandom);
            case (op)
                0: begin do_write(1'b0, d, 1'b1); m_tx = d; check_outs("R3 random tx"); end
                1: begin do_write(1'b1, d, 1'b1); model_ctl(d); check_outs("R6 random ctl"); end
                2: begin
                    rx_digit = d;
                    do_read(1'b0, 0, v);
                    check("R4 random rx", {28'd0, v}, {28'd0, d});
                end
                3: begin rx_invalid = d[2]; pulse(d[0], d[1]); end
                default: status_read("R7 random status");
            endcase
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule